// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a NOR-style parallel flash model. It watches write bus cycles, each carrying an address and a 16-bit data word, and interprets the low byte of the data as a command code. Single-cycle commands change the read mode, clear the status register or request suspend and resume. Multi-cycle commands collect their operands and confirm codes before launching an operation. Array storage, program and erase timing, status bit meaning and identifier contents belong to a back end. That back end receives a one-cycle operation strobe with a kind code, an address and a data word.

A prefix code of 0x60 is followed by a second byte that selects one of four actions: lock, unlock, lock-down or configuration write. Buffered program and the extended function command load a counted run of data words into an internal word buffer before they require a confirm. The back end reads that buffer through a read port. A malformed sequence, such as a wrong confirm, a block mismatch, a word outside the buffer window or an oversized count, is abandoned. It raises a sticky sequence-error flag and forces status read mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, rd_mode is 0 (array), op_valid is 0 and seq_err is 0, whatever came before the reset.
- R2: In the idle state the command byte is wr_data[7:0] and the upper byte is ignored. 0xFF sets rd_mode 0 (array), 0x90 sets 1 (identifier), 0x98 sets 2 (query) and 0x70 sets 3 (status), and none of them issues an operation. rd_mode never changes in a cycle that follows no write.
- R3: 0x50 issues op_kind 1 (clear status) in a single write and clears seq_err.
- R4: 0x40, followed by a write in the same block (the same wr_addr[23:16]), issues op_kind 2 (word program) with op_addr and op_data taken from the second write. rd_mode becomes 3.
- R5: 0x20 followed by 0xD0 in the same block issues op_kind 3 (block erase). 0xBC followed by 0xD0 in the same block issues op_kind 4 (blank check). Both set rd_mode to 3.
- R6: After 0x60, a second byte in the same block selects the action: 0x01 gives op_kind 5 (lock), 0xD0 gives 6 (unlock), 0x2F gives 7 (lock-down) and 0x03 gives 8 (configuration write). For a configuration write, op_data is wr_addr[16:1] of the second cycle. None of these changes rd_mode.
- R7: In a multi-cycle sequence, a second or confirm cycle with an unexpected code or an address in another block issues no operation. It sets seq_err, sets rd_mode to 3 and returns to idle.
- R8: Buffered program is 0xE8, then a count cycle carrying N-1, then N data words. Each word is stored at buffer index wr_addr[9:1]. A final 0xD0 then issues op_kind 12 with op_addr set to the first address and op_data set to N-1. The stored words are readable on buf_rdata, and buf_len holds N-1.
- R9: A count above 511 is rejected. A data word whose wr_addr[23:10] differs from that of the first cycle aborts the sequence. Both cases behave as in R7. A count of 511 (512 words) is accepted.
- R10: 0xC0, followed by a write in the same block, issues op_kind 9 (OTP or lock register program) with the second cycle's address and data. 0xB0 alone issues op_kind 10 (suspend), and 0xD0 alone in idle issues op_kind 11 (resume).
- R11: The extended function command is 0xEB, then a sub-opcode cycle, then a count of N-1, then N data words, then 0xD0. It issues op_kind 13 with op_data equal to the sub-opcode, and buf_len holds N-1.
- R12: op_valid is high for exactly the one cycle after the write that completes a command. An unrecognised command byte in idle issues nothing and leaves rd_mode and seq_err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A write bus cycle is present this clock |
| wr_addr | input | 24 | Write cycle address |
| wr_data | input | 16 | Write cycle data |
| rd_mode | output | 2 | Current read mode: 0 array, 1 identifier, 2 query, 3 status |
| seq_err | output | 1 | Sticky command-sequence error flag |
| op_valid | output | 1 | One-cycle operation strobe |
| op_kind | output | 4 | Operation code that goes with op_valid |
| op_addr | output | 24 | Operation target address |
| op_data | output | 16 | Operation data word, count or sub-opcode |
| buf_raddr | input | 9 | Word buffer read index |
| buf_rdata | output | 16 | Word buffer read data |
| buf_len | output | 9 | Stored word count minus one |

## Verification
A table of single writes covers every read-mode code, the erase and blank-check confirm pairs, and all four second bytes after the 0x60 prefix. The same table drives a confirm sent to a different block and a confirm with a wrong code, which shows whether the block comparison and the code comparison are each enforced. Buffered loads are written out of index order, so a buffer that stores by arrival order fails the readback checks. Counts of 0, 3, 511 and 512, together with a word just outside the buffer window, probe the limits of the load phase. A non-command byte and a command placed under a non-zero upper byte show that only the low byte is decoded.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_QUERY  = 2'd2,
        RD_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_CLR_STATUS = 4'd1,
        OP_WORD_PROG  = 4'd2,
        OP_ERASE      = 4'd3,
        OP_BLANK      = 4'd4,
        OP_LOCK       = 4'd5,
        OP_UNLOCK     = 4'd6,
        OP_LOCKDOWN   = 4'd7,
        OP_CFG_WR     = 4'd8,
        OP_OTP_PROG   = 4'd9,
        OP_SUSPEND    = 4'd10,
        OP_RESUME     = 4'd11,
        OP_BUF_PROG   = 4'd12,
        OP_EXT_FUNC   = 4'd13
    } op_e;

    typedef enum logic [3:0] {
        CMD_NONE, CMD_RD_ARRAY, CMD_RD_IDENT, CMD_RD_QUERY, CMD_RD_STATUS,
        CMD_CLR_STATUS, CMD_WORD_PROG, CMD_ERASE, CMD_SETUP, CMD_BUF_PROG,
        CMD_OTP, CMD_BLANK, CMD_EXT, CMD_SUSPEND, CMD_CONFIRM
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DATA, ST_CONFIRM, ST_SETUP, ST_SUB, ST_COUNT, ST_LOAD, ST_BUF_CONF
    } state_e;

    localparam logic [7:0] CODE_CONFIRM = 8'hD0;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_e       cmd,
    output op_e        setup_op
);

    always_comb begin
        unique case (cmd_byte)
            8'hFF:   cmd = CMD_RD_ARRAY;
            8'h90:   cmd = CMD_RD_IDENT;
            8'h98:   cmd = CMD_RD_QUERY;
            8'h70:   cmd = CMD_RD_STATUS;
            8'h50:   cmd = CMD_CLR_STATUS;
            8'h40:   cmd = CMD_WORD_PROG;
            8'h20:   cmd = CMD_ERASE;
            8'h60:   cmd = CMD_SETUP;
            8'hE8:   cmd = CMD_BUF_PROG;
            8'hC0:   cmd = CMD_OTP;
            8'hBC:   cmd = CMD_BLANK;
            8'hEB:   cmd = CMD_EXT;
            8'hB0:   cmd = CMD_SUSPEND;
            8'hD0:   cmd = CMD_CONFIRM;
            default: cmd = CMD_NONE;
        endcase
    end

    // second byte after the 0x60 prefix
    always_comb begin
        unique case (cmd_byte)
            8'h01:   setup_op = OP_LOCK;
            8'hD0:   setup_op = OP_UNLOCK;
            8'h2F:   setup_op = OP_LOCKDOWN;
            8'h03:   setup_op = OP_CFG_WR;
            default: setup_op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
    parameter  int DEPTH = 512,
    parameter  int DW    = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter  int ADDR_W  = 24,
    parameter  int BLK_AW  = 16,
    parameter  int BUF_MAX = 512,
    localparam int BUF_AW  = $clog2(BUF_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic [1:0]        rd_mode,
    output logic              seq_err,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    input  logic [BUF_AW-1:0] buf_raddr,
    output logic [15:0]       buf_rdata,
    output logic [BUF_AW-1:0] buf_len
);

    localparam logic [15:0] MAX_COUNT = 16'(BUF_MAX - 1);

    typedef struct packed {
        state_e            st;
        logic              efi;
        op_e               pend;
        logic [ADDR_W-1:0] base;
        logic [15:0]       sub;
        logic [BUF_AW-1:0] cnt;
        logic [BUF_AW-1:0] loaded;
        rd_mode_e          rd;
        logic              err;
        logic              op_v;
        op_e               op_k;
        logic [ADDR_W-1:0] op_a;
        logic [15:0]       op_d;
    } seq_t;

    seq_t r_q, r_d;

    cmd_e cmd;
    op_e  setup_op;
    logic same_blk, in_win, is_conf;
    logic buf_we;

    flash_cmd_decode i_decode (
        .cmd_byte (wr_data[7:0]),
        .cmd      (cmd),
        .setup_op (setup_op)
    );

    flash_wbuf #(.DEPTH(BUF_MAX), .DW(16)) i_wbuf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (wr_addr[BUF_AW:1]),
        .wdata (wr_data),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    assign same_blk = wr_addr[ADDR_W-1:BLK_AW] == r_q.base[ADDR_W-1:BLK_AW];
    assign in_win   = wr_addr[ADDR_W-1:BUF_AW+1] == r_q.base[ADDR_W-1:BUF_AW+1];
    assign is_conf  = wr_data[7:0] == CODE_CONFIRM;

    always_comb begin
        r_d      = r_q;
        r_d.op_v = 1'b0;
        r_d.op_k = OP_NONE;
        buf_we   = 1'b0;
        if (wr_en) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.base = wr_addr;
                    unique case (cmd)
                        CMD_RD_ARRAY:  r_d.rd = RD_ARRAY;
                        CMD_RD_IDENT:  r_d.rd = RD_IDENT;
                        CMD_RD_QUERY:  r_d.rd = RD_QUERY;
                        CMD_RD_STATUS: r_d.rd = RD_STATUS;
                        CMD_CLR_STATUS: begin
                            r_d.err  = 1'b0;
                            r_d.op_v = 1'b1;
                            r_d.op_k = OP_CLR_STATUS;
                            r_d.op_a = wr_addr;
                            r_d.op_d = '0;
                        end
                        CMD_WORD_PROG: begin
                            r_d.st   = ST_DATA;
                            r_d.pend = OP_WORD_PROG;
                        end
                        CMD_OTP: begin
                            r_d.st   = ST_DATA;
                            r_d.pend = OP_OTP_PROG;
                        end
                        CMD_ERASE: begin
                            r_d.st   = ST_CONFIRM;
                            r_d.pend = OP_ERASE;
                        end
                        CMD_BLANK: begin
                            r_d.st   = ST_CONFIRM;
                            r_d.pend = OP_BLANK;
                        end
                        CMD_SETUP: r_d.st = ST_SETUP;
                        CMD_BUF_PROG: begin
                            r_d.st  = ST_COUNT;
                            r_d.efi = 1'b0;
                        end
                        CMD_EXT: begin
                            r_d.st  = ST_SUB;
                            r_d.efi = 1'b1;
                        end
                        CMD_SUSPEND, CMD_CONFIRM: begin
                            r_d.op_v = 1'b1;
                            r_d.op_k = (cmd == CMD_SUSPEND) ? OP_SUSPEND : OP_RESUME;
                            r_d.op_a = wr_addr;
                            r_d.op_d = '0;
                        end
                        default: ;
                    endcase
                end
                ST_DATA: begin
                    r_d.st = ST_IDLE;
                    r_d.rd = RD_STATUS;
                    if (same_blk) begin
                        r_d.op_v = 1'b1;
                        r_d.op_k = r_q.pend;
                        r_d.op_a = wr_addr;
                        r_d.op_d = wr_data;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
                ST_CONFIRM: begin
                    r_d.st = ST_IDLE;
                    r_d.rd = RD_STATUS;
                    if (same_blk && is_conf) begin
                        r_d.op_v = 1'b1;
                        r_d.op_k = r_q.pend;
                        r_d.op_a = r_q.base;
                        r_d.op_d = '0;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
                ST_SETUP: begin
                    r_d.st = ST_IDLE;
                    if (same_blk && setup_op != OP_NONE) begin
                        r_d.op_v = 1'b1;
                        r_d.op_k = setup_op;
                        r_d.op_a = r_q.base;
                        r_d.op_d = (setup_op == OP_CFG_WR) ? wr_addr[16:1] : '0;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.rd  = RD_STATUS;
                    end
                end
                ST_SUB: begin
                    if (same_blk) begin
                        r_d.sub = wr_data;
                        r_d.st  = ST_COUNT;
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.err = 1'b1;
                        r_d.rd  = RD_STATUS;
                    end
                end
                ST_COUNT: begin
                    if (same_blk && wr_data <= MAX_COUNT) begin
                        r_d.cnt    = wr_data[BUF_AW-1:0];
                        r_d.loaded = '0;
                        r_d.st     = ST_LOAD;
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.err = 1'b1;
                        r_d.rd  = RD_STATUS;
                    end
                end
                ST_LOAD: begin
                    if (in_win) begin
                        buf_we = 1'b1;
                        if (r_q.loaded == r_q.cnt) begin
                            r_d.st = ST_BUF_CONF;
                        end else begin
                            r_d.loaded = r_q.loaded + 1'b1;
                        end
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.err = 1'b1;
                        r_d.rd  = RD_STATUS;
                    end
                end
                ST_BUF_CONF: begin
                    r_d.st = ST_IDLE;
                    r_d.rd = RD_STATUS;
                    if (same_blk && is_conf) begin
                        r_d.op_v = 1'b1;
                        r_d.op_k = r_q.efi ? OP_EXT_FUNC : OP_BUF_PROG;
                        r_d.op_a = r_q.base;
                        r_d.op_d = r_q.efi ? r_q.sub : 16'(r_q.cnt);
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_mode  = r_q.rd;
    assign seq_err  = r_q.err;
    assign op_valid = r_q.op_v;
    assign op_kind  = r_q.op_k;
    assign op_addr  = r_q.op_a;
    assign op_data  = r_q.op_d;
    assign buf_len  = r_q.cnt;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] rd_mode,
    input logic       seq_err,
    input logic       op_valid,
    input logic [3:0] op_kind
);

    AST_OP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_en)); // R12

    AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rd_mode)); // R2

    AST_ERR_FORCES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> rd_mode == 2'd3); // R7

    AST_PROG_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind inside {4'd2, 4'd3, 4'd4, 4'd9, 4'd12, 4'd13}) |-> rd_mode == 2'd3); // R4

    AST_CLEAR_DROPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd1) |-> !seq_err); // R3

    AST_ERR_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_err) |-> $past(wr_en)); // R3

    AST_PROTECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind inside {4'd5, 4'd6, 4'd7, 4'd8}) |-> $stable(rd_mode)); // R6

endmodule

bind flash_cmd_seq flash_cmd_seq_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_mode  (rd_mode),
    .seq_err  (seq_err),
    .op_valid (op_valid),
    .op_kind  (op_kind)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_mode;
    logic        seq_err;
    logic        op_valid;
    logic [3:0]  op_kind;
    logic [23:0] op_addr;
    logic [15:0] op_data;
    logic [8:0]  buf_raddr = '0;
    logic [15:0] buf_rdata;
    logic [8:0]  buf_len;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_mode   (rd_mode),
        .seq_err   (seq_err),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .buf_raddr (buf_raddr),
        .buf_rdata (buf_rdata),
        .buf_len   (buf_len)
    );

    // {req, addr, data, valid, kind, rd_mode, err}
    localparam int NV = 27;
    localparam logic [51:0] VEC [NV] = '{
        {4'd2,  24'h000000, 16'h0090, 1'b0, 4'd0,  2'd1, 1'b0}, // R2 identifier
        {4'd2,  24'h000000, 16'h0098, 1'b0, 4'd0,  2'd2, 1'b0}, // R2 query
        {4'd2,  24'h000000, 16'h0070, 1'b0, 4'd0,  2'd3, 1'b0}, // R2 status
        {4'd2,  24'h000000, 16'h00FF, 1'b0, 4'd0,  2'd0, 1'b0}, // R2 array
        {4'd5,  24'h010000, 16'h0020, 1'b0, 4'd0,  2'd0, 1'b0}, // R5 erase setup
        {4'd5,  24'h01FFFE, 16'h00D0, 1'b1, 4'd3,  2'd3, 1'b0}, // R5 erase confirm
        {4'd2,  24'h000000, 16'h00FF, 1'b0, 4'd0,  2'd0, 1'b0}, // R2
        {4'd5,  24'h020000, 16'h00BC, 1'b0, 4'd0,  2'd0, 1'b0}, // R5 blank setup
        {4'd5,  24'h020010, 16'h00D0, 1'b1, 4'd4,  2'd3, 1'b0}, // R5 blank confirm
        {4'd6,  24'h030000, 16'h0060, 1'b0, 4'd0,  2'd3, 1'b0}, // R6
        {4'd6,  24'h030000, 16'h0001, 1'b1, 4'd5,  2'd3, 1'b0}, // R6 lock
        {4'd6,  24'h030002, 16'h0060, 1'b0, 4'd0,  2'd3, 1'b0}, // R6
        {4'd6,  24'h030002, 16'h00D0, 1'b1, 4'd6,  2'd3, 1'b0}, // R6 unlock
        {4'd6,  24'h030004, 16'h0060, 1'b0, 4'd0,  2'd3, 1'b0}, // R6
        {4'd6,  24'h030004, 16'h002F, 1'b1, 4'd7,  2'd3, 1'b0}, // R6 lock-down
        {4'd4,  24'h040000, 16'h0040, 1'b0, 4'd0,  2'd3, 1'b0}, // R4
        {4'd4,  24'h040002, 16'h1234, 1'b1, 4'd2,  2'd3, 1'b0}, // R4 word program
        {4'd7,  24'h050000, 16'h0020, 1'b0, 4'd0,  2'd3, 1'b0}, // R7
        {4'd7,  24'h060000, 16'h00D0, 1'b0, 4'd0,  2'd3, 1'b1}, // R7 other block
        {4'd3,  24'h000000, 16'h0050, 1'b1, 4'd1,  2'd3, 1'b0}, // R3 clear
        {4'd7,  24'h050000, 16'h0020, 1'b0, 4'd0,  2'd3, 1'b0}, // R7
        {4'd7,  24'h050000, 16'h00D1, 1'b0, 4'd0,  2'd3, 1'b1}, // R7 wrong code
        {4'd3,  24'h000000, 16'h0050, 1'b1, 4'd1,  2'd3, 1'b0}, // R3 clear
        {4'd10, 24'h000000, 16'h00B0, 1'b1, 4'd10, 2'd3, 1'b0}, // R10 suspend
        {4'd10, 24'h000000, 16'h00D0, 1'b1, 4'd11, 2'd3, 1'b0}, // R10 resume
        {4'd12, 24'h000000, 16'h0042, 1'b0, 4'd0,  2'd3, 1'b0}, // R12 unknown byte
        {4'd2,  24'h000000, 16'hA5FF, 1'b0, 4'd0,  2'd0, 1'b0}  // R2 upper byte ignored
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", "rd_mode", 32'(rd_mode), 0);
        check("R1", "op_valid", 32'(op_valid), 0);
        check("R1", "seq_err", 32'(seq_err), 0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [23:0] a;
            logic [15:0] d;
            logic ev, ee;
            logic [3:0] ek;
            logic [1:0] er;
            string tag;
            {rq, a, d, ev, ek, er, ee} = VEC[i];
            tag = $sformatf("R%0d row%0d", rq, i);
            wr(a, d);
            check(tag, "op_valid", 32'(op_valid), 32'(ev));
            if (ev) check(tag, "op_kind", 32'(op_kind), 32'(ek));
            check(tag, "rd_mode", 32'(rd_mode), 32'(er));
            check(tag, "seq_err", 32'(seq_err), 32'(ee));
        end

        // R4 word program operands
        wr(24'h040000, 16'h0040);
        wr(24'h040ABC, 16'hCAFE);
        check("R4", "op_kind", 32'(op_kind), 2);
        check("R4", "op_addr", 32'(op_addr), 32'h040ABC);
        check("R4", "op_data", 32'(op_data), 32'hCAFE);

        // R6 configuration write takes address bits 16:1
        wr(24'h000000, 16'h00FF);
        wr(24'h010000, 16'h0060);
        wr(24'h015678, 16'h0003);
        check("R6", "op_kind", 32'(op_kind), 8);
        check("R6", "op_data", 32'(op_data), 32'hAB3C);
        check("R6", "rd_mode", 32'(rd_mode), 0);

        // R10 OTP program
        wr(24'h000100, 16'h00C0);
        wr(24'h000102, 16'hBEEF);
        check("R10", "op_kind", 32'(op_kind), 9);
        check("R10", "op_addr", 32'(op_addr), 32'h000102);
        check("R10", "op_data", 32'(op_data), 32'hBEEF);

        // R8 buffered program, words written out of index order
        wr(24'h080000, 16'h00E8);
        wr(24'h080000, 16'd3);
        wr(24'h080006, 16'hD003);
        check("R8", "no op while loading", 32'(op_valid), 0);
        wr(24'h080000, 16'hD000);
        wr(24'h080004, 16'hD002);
        wr(24'h080002, 16'hD001);
        check("R8", "no op before confirm", 32'(op_valid), 0);
        wr(24'h080000, 16'h00D0);
        check("R8", "op_kind", 32'(op_kind), 12);
        check("R8", "op_addr", 32'(op_addr), 32'h080000);
        check("R8", "op_data", 32'(op_data), 3);
        check("R8", "buf_len", 32'(buf_len), 3);
        check("R8", "rd_mode", 32'(rd_mode), 3);
        for (int k = 0; k < 4; k++) begin
            buf_raddr = 9'(k);
            #1;
            check("R8", "buf_rdata", 32'(buf_rdata), 32'(16'hD000 + k));
        end

        // R8 single word (count 0)
        wr(24'h0C0000, 16'h00E8);
        wr(24'h0C0000, 16'd0);
        wr(24'h0C0010, 16'h7777);
        wr(24'h0C0000, 16'h00D0);
        check("R8", "N=1 op_kind", 32'(op_kind), 12);
        check("R8", "N=1 op_data", 32'(op_data), 0);
        buf_raddr = 9'd8;
        #1;
        check("R8", "N=1 buf_rdata", 32'(buf_rdata), 32'h7777);

        // R9 count 512 rejected
        wr(24'h090000, 16'h00E8);
        wr(24'h090000, 16'd512);
        check("R9", "count reject err", 32'(seq_err), 1);
        check("R9", "count reject rd_mode", 32'(rd_mode), 3);
        wr(24'h000000, 16'h0050);

        // R9 word outside the buffer window
        wr(24'h080000, 16'h00E8);
        wr(24'h080000, 16'd1);
        wr(24'h080000, 16'h1111);
        check("R9", "in-window err", 32'(seq_err), 0);
        wr(24'h080400, 16'h2222);
        check("R9", "window abort err", 32'(seq_err), 1);
        wr(24'h080000, 16'h00D0);
        check("R9", "aborted confirm is resume", 32'(op_kind), 11);
        wr(24'h000000, 16'h0050);
        check("R3", "err cleared", 32'(seq_err), 0);

        // R9 largest count accepted
        wr(24'h0A0000, 16'h00E8);
        wr(24'h0A0000, 16'd511);
        for (int k = 0; k < 512; k++) wr(24'h0A0000 + 24'(2 * k), 16'(k) ^ 16'h5A5A);
        check("R9", "max count err", 32'(seq_err), 0);
        wr(24'h0A0000, 16'h00D0);
        check("R9", "max count op_kind", 32'(op_kind), 12);
        check("R9", "max count op_data", 32'(op_data), 511);
        buf_raddr = 9'd511;
        #1;
        check("R9", "last word", 32'(buf_rdata), 32'(16'd511 ^ 16'h5A5A));

        // R11 extended function
        wr(24'h0B0000, 16'h00EB);
        wr(24'h0B0000, 16'h0077);
        wr(24'h0B0000, 16'd1);
        wr(24'h0B0000, 16'h3030);
        wr(24'h0B0002, 16'h3131);
        wr(24'h0B0000, 16'h00D0);
        check("R11", "op_kind", 32'(op_kind), 13);
        check("R11", "op_data", 32'(op_data), 32'h77);
        check("R11", "buf_len", 32'(buf_len), 1);
        buf_raddr = 9'd1;
        #1;
        check("R11", "buf_rdata", 32'(buf_rdata), 32'h3131);

        // R7 missing confirm after load, bad byte after 0x60
        wr(24'h000000, 16'h00FF);
        wr(24'h0C0000, 16'h00E8);
        wr(24'h0C0000, 16'd0);
        wr(24'h0C0000, 16'h1234);
        wr(24'h0C0000, 16'h0070);
        check("R7", "missing confirm op", 32'(op_valid), 0);
        check("R7", "missing confirm err", 32'(seq_err), 1);
        wr(24'h000000, 16'h0050);
        wr(24'h000000, 16'h00FF);
        wr(24'h030000, 16'h0060);
        wr(24'h030000, 16'h0055);
        check("R7", "bad setup op", 32'(op_valid), 0);
        check("R7", "bad setup err", 32'(seq_err), 1);
        check("R7", "bad setup rd_mode", 32'(rd_mode), 3);

        // R12 strobe lasts one cycle
        wr(24'h000000, 16'h00B0);
        check("R12", "strobe high", 32'(op_valid), 1);
        @(negedge clk);
        check("R12", "strobe gone", 32'(op_valid), 0);

        // R1 reset mid-run with error set
        do_reset();
        check("R1", "rd_mode after reset", 32'(rd_mode), 0);
        check("R1", "seq_err after reset", 32'(seq_err), 0);
        check("R1", "op_valid after reset", 32'(op_valid), 0);

        finish_run();
    end

endmodule